// File: doc/BRIEF.md
# Prescaled Interval Timer (Delay Mode)

This block is an 8-bit interval timer that counts down. It is paced by a timer clock that reaches it as a synchronous enable, `tick_en`. That enable first passes through a prescaler whose divide ratio comes from a 3-bit code. Each time the count runs out, the block reloads the count from a held reload value and raises a one-cycle `expire` pulse, which serves as an interrupt request. It then keeps running without help.

Software writes a 3-bit control code and an 8-bit data value through a single write port, and it can read the live count at any time. Control code zero halts the timer. Data value zero gives a full period of 256 prescaled ticks. For example, a 2.4576 MHz timer clock, divided by 200, with a count of 256, gives an expiry rate of 48 Hz.

Top module: `ivl_timer`

## Requirements
- R1: While reset is active and after it is released, `expire` is 0, `count` is 0 and the control code is 0, so the timer is stopped.
- R2: With control code 0, the timer produces no `expire` pulse and `count` holds its value whatever `tick_en` does.
- R3: A write with `wr_sel`=0 stores `wr_data[2:0]` as the control code. Codes 1 through 7 divide the `tick_en` cycles by 4, 10, 16, 50, 64, 100 and 200 respectively.
- R4: While running with data value N, `expire` fires every ratio×N enabled `tick_en` cycles, and N=0 counts as 256. The first pulse comes ratio×N enabled cycles after the clock edge that captures the control write.
- R5: A write with `wr_sel`=1 while the timer is stopped loads `wr_data` into both the reload value and `count`. The new value is visible one cycle later.
- R6: A data write while the timer is running changes only the reload value. `count` keeps counting from where it was, and the new value first governs the period that starts at the next expiry.
- R7: On the prescaled tick that expires the count, `count` reloads in that same tick. Right after `expire` rises, `count` equals the reload value, and no extra cycle is added to the period.
- R8: Any write to the control code restarts the prescaler from zero.
- R9: `expire` is a registered pulse exactly one `clk` cycle wide. Cycles with `tick_en`=0 do not advance the prescaler or the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Timer clock, one-cycle enable per timer tick |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control code, 1 selects the data value |
| wr_data | input | 8 | Write data |
| expire | output | 1 | One-cycle expiry (interrupt request) pulse |
| count | output | 8 | Current count value |

## Verification
The main delay function is tried with every divide code at small data values. A short-ratio run with N=3 confirms that the expiry cycle equals ratio×N and that the reload lands in the same tick. The ratio-200 run at N=0 separates 256 from 0-length and 255-length periods. Changing the code in the middle of a prescale interval tells a restarted prescaler from one that carries its old phase. A write while running tells a reload-only update from a direct count load. A stretch with `tick_en` held low shifts every later expiry by exactly the idle length, which shows that idle cycles leave both stages frozen.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
  localparam int CODE_W = 3;

  // divide ratio minus one for each control code; code 0 is stopped
  function automatic logic [7:0] ratio_m1(input logic [CODE_W-1:0] code);
    logic [7:0] r;
    case (code)
      3'd1:    r = 8'd3;
      3'd2:    r = 8'd9;
      3'd3:    r = 8'd15;
      3'd4:    r = 8'd49;
      3'd5:    r = 8'd63;
      3'd6:    r = 8'd99;
      3'd7:    r = 8'd199;
      default: r = 8'd0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ivl_prescale.sv
module ivl_prescale
  import ivl_timer_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              tick_en,
  input  logic              restart,
  output logic              pre_tick
);
  logic [PRE_W-1:0] pcnt_q, pcnt_d;
  logic [PRE_W-1:0] limit;
  logic             run;

  assign run      = (code != '0);
  assign limit    = PRE_W'(ratio_m1(code));
  assign pre_tick = run && tick_en && (pcnt_q == limit);

  always_comb begin
    pcnt_d = pcnt_q;
    if (restart || !run) begin
      pcnt_d = '0;
    end else if (tick_en) begin
      if (pcnt_q == limit) pcnt_d = '0;
      else                 pcnt_d = pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/ivl_downcount.sv
module ivl_downcount #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_tick,
  input  logic             load_now,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             exp_q, exp_d;

  always_comb begin
    cnt_d = cnt_q;
    exp_d = 1'b0;
    if (load_now) begin
      cnt_d = load_val;
    end else if (pre_tick) begin
      if (cnt_q == ONE) begin
        cnt_d = reload_val;
        exp_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;   // 0 wraps to the top: full-length period
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign cnt    = cnt_q;
  assign expire = exp_q;
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             expire,
  output logic [CNT_W-1:0] count
);
  // reset: asserted asynchronously, released through a short shift chain
  logic [SYNC_N-1:0] rsync_q;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rsync_q[SYNC_N-1];

  // control and reload registers
  logic [CODE_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  reload_q, reload_d;
  logic              ctrl_wr, data_wr, stopped;

  assign ctrl_wr = wr_en && !wr_sel;
  assign data_wr = wr_en &&  wr_sel;
  assign stopped = (ctrl_q == '0);

  always_comb begin
    ctrl_d   = ctrl_q;
    reload_d = reload_q;
    if (ctrl_wr) ctrl_d   = wr_data[CODE_W-1:0];
    if (data_wr) reload_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
    end
  end

  logic pre_tick;

  ivl_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .code     (ctrl_q),
    .tick_en  (tick_en),
    .restart  (ctrl_wr),
    .pre_tick (pre_tick)
  );

  ivl_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pre_tick   (pre_tick),
    .load_now   (data_wr && stopped),
    .load_val   (wr_data),
    .reload_val (reload_q),
    .cnt        (count),
    .expire     (expire)
  );
endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_i_n,
  input logic             tick_en,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic             expire,
  input logic [CNT_W-1:0] count,
  input logic [2:0]       ctrl_q,
  input logic [CNT_W-1:0] reload_q
);
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    expire |=> !expire); // R9

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ctrl_q == 3'd0) |=> !expire); // R2

  AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!tick_en && !(wr_en && wr_sel)) |=> $stable(count)); // R9

  AST_RELOAD_SAME_TICK: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(expire) |-> (count == $past(reload_q))); // R7

  AST_STOPPED_LOAD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_en && wr_sel && ctrl_q == 3'd0) |=> (count == $past(wr_data))); // R5

  AST_RUNNING_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_en && wr_sel && ctrl_q != 3'd0 && !tick_en) |=> $stable(count)); // R6
endmodule

bind ivl_timer ivl_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_i_n  (rst_int_n),
  .tick_en  (tick_en),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .expire   (expire),
  .count    (count),
  .ctrl_q   (ctrl_q),
  .reload_q (reload_q)
);

// File: tb/tb_ivl_timer.sv
module tb_ivl_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       expire;
  logic [7:0] count;

  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  ivl_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .expire(expire), .count(count)
  );

  // monitor: every observed expiry is matched against the scoreboard
  always @(negedge clk) begin
    if (rst_n && expire) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R4 unexpected expiry at cycle %0d expected none", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          mismatched++;
          $display("FAIL R4 expiry at cycle %0d expected %0d", cyc, e);
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic wr(input bit sel, input logic [7:0] v);
    wr_en = 1'b1; wr_sel = sel; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic drained(input string req);
    check({req, " pending expiries"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  // driver: start from stopped, push expected expiry cycles, stop mid-period
  task automatic run_case(input logic [2:0] code, input logic [7:0] n,
                          input int ratio, input int k, input string req);
    int p, c;
    p = ratio * ((n == 0) ? 256 : int'(n));
    wr(1'b1, n);
    c = cyc;
    for (int i = 1; i <= k; i++) exp_q.push_back(c + 1 + p * i);
    wr(1'b0, {5'd0, code});
    wait_until(c + 1 + p);
    check({req, " R7 count after expiry"}, count, n);
    wait_until(c + 1 + p * k + p / 2);
    wr(1'b0, 8'd0);
    repeat (4) @(negedge clk);
    drained(req);
  endtask

  initial begin
    int ratios[7] = '{4, 10, 16, 50, 64, 100, 200};
    int c;
    repeat (3) @(negedge clk);
    check("R1 expire in reset", expire, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 expire after reset", expire, 0);
    check("R1 count after reset", count, 0);

    // R4/R7: ratio 4, N=3
    run_case(3'd1, 8'd3, 4, 3, "R4 code1");
    // R3: every other short ratio
    for (int cd = 2; cd <= 6; cd++) run_case(3'(cd), 8'd2, ratios[cd-1], 2, "R3 ratio");

    // R5: load while stopped
    wr(1'b1, 8'd9);
    check("R5 stopped load", count, 9);
    // R2: stopped timer stays quiet with tick_en active
    repeat (300) @(negedge clk);
    check("R2 count held while stopped", count, 9);
    drained("R2");

    // R6: write while running touches reload only
    wr(1'b1, 8'd5);
    c = cyc;
    exp_q.push_back(c + 21); exp_q.push_back(c + 29); exp_q.push_back(c + 37);
    wr(1'b0, 8'd1);
    wr(1'b1, 8'd2);
    check("R6 count unchanged by running write", count, 5);
    wait_until(c + 21);
    check("R6 new reload after expiry", count, 2);
    wait_until(c + 41);
    wr(1'b0, 8'd0);
    repeat (4) @(negedge clk);
    drained("R6");

    // R8: code change mid-interval restarts prescaler
    wr(1'b1, 8'd1);
    c = cyc;
    wr(1'b0, 8'd1);
    wait_until(c + 3);
    exp_q.push_back(c + 14); exp_q.push_back(c + 24);
    wr(1'b0, 8'd2);
    wait_until(c + 29);
    wr(1'b0, 8'd0);
    repeat (4) @(negedge clk);
    drained("R8");

    // R9: idle tick_en stretch shifts expiry by its length
    wr(1'b1, 8'd2);
    c = cyc;
    exp_q.push_back(c + 59); exp_q.push_back(c + 67);
    wr(1'b0, 8'd1);
    wait_until(c + 6);
    tick_en = 1'b0;
    wait_until(c + 30);
    check("R9 count frozen while idle", count, 1);
    wait_until(c + 56);
    tick_en = 1'b1;
    wait_until(c + 70);
    wr(1'b0, 8'd0);
    repeat (4) @(negedge clk);
    drained("R9");

    // R4: ratio 200, N=0 -> 51200 cycles per period (48 Hz at 2.4576 MHz)
    run_case(3'd7, 8'd0, 200, 2, "R4 code7 full");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule